// File: doc/BRIEF.md
# FFT Output Unscrambler

This block sits behind the final stage of a single-path streaming FFT and returns each frame to natural frequency order. The upstream stage delivers a frame of N = 2^LOG2N complex samples as four quarters in natural quarter order. Inside each quarter the low LOG2N-2 index bits arrive reversed. Fixing that order takes only one quarter-frame of storage, M = N/4 words, instead of a full-frame ping-pong memory.

Each accepted input word reads one buffer location and overwrites it in the same cycle. The address order alternates between quarters. Even quarters (0 and 2) are written at natural addresses and drain in reversed order. Odd quarters (1 and 3) are written at reversed addresses and drain in natural order. Because every slot is refilled the moment it empties, frames stream back to back with no idle cycles. The delay is a fixed M+1 cycles under continuous input. The block does no arithmetic and no scaling. LOG2N must be at least 3.

Top module: `fft_unscrambler`

## Requirements
- R1: While reset is high, and in the cycle after, out_valid and out_sof are low and out_re and out_im are zero; reset empties the buffer and restarts frame counting.
- R2: out_valid is high only in the cycle after a cycle with in_valid high. The first M = N/4 accepted samples after reset produce no output. Every later accepted sample produces exactly one output in the next cycle.
- R3: A frame is N accepted samples. Quarter b (0..3) arrives in order. Within a quarter, the sample at offset c carries natural index b*M + rev(c), where rev reverses the LOG2N-2 bits of c. The k-th output after reset (k from 0) is the k-th sample of the input stream in natural order, frame after frame. It appears in the cycle after accepted input number k+M (counted from 0).
- R4: With in_valid held high, out_valid stays high every cycle once the first M samples have been taken, including across frame boundaries.
- R5: out_sof is high exactly in the cycles whose output carries natural index 0 of a frame, and it is never high without out_valid.
- R6: In the cycle after an input cycle with in_valid low, out_valid is low and out_re and out_im keep their values. Idle cycles do not disturb the output order.
- R7: out_re and out_im are the input values, bit for bit, with no scaling. This includes the extremes -2^(W-1) and 2^(W-1)-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present this cycle |
| in_re | input | W | Real part of input sample |
| in_im | input | W | Imaginary part of input sample |
| out_valid | output | 1 | Output word present this cycle |
| out_sof | output | 1 | Output carries natural index 0 of a frame |
| out_re | output | W | Real part of output sample |
| out_im | output | W | Imaginary part of output sample |

## Verification
Each real part is tagged with the sample's natural index. Ascending tags at the output therefore show directly whether the reversed-address and natural-address quarters alternate correctly, including across back-to-back frames.

The block is driven with three kinds of input:
- An unbroken stream. This separates a correct fixed M+1 latency and gap-free output from an off-by-one in the priming count or a lost quarter boundary.
- A stream with random idle cycles. This tells apart a design that advances its address counters only on accepted words from one that advances on every clock.
- Directed extreme values and a reset in mid-frame. These expose any altered data bits, and any state left over from before the reset.

// File: rtl/unscr_pkg.sv
`timescale 1ns/1ps
package unscr_pkg;

    typedef enum logic {
        ADDR_NATURAL  = 1'b0,
        ADDR_REVERSED = 1'b1
    } addr_mode_e;

    // Even quarters use natural slot order for writing, odd quarters reversed.
    function automatic addr_mode_e mode_of_quarter(input logic [1:0] quarter);
        return quarter[0] ? ADDR_REVERSED : ADDR_NATURAL;
    endfunction

    // Output of quarter 0 starts while quarter 1 is being written.
    localparam logic [1:0] SOF_QUARTER = 2'd1;

endpackage

// File: rtl/unscr_addr_gen.sv
`timescale 1ns/1ps
module unscr_addr_gen
    import unscr_pkg::*;
#(
    parameter int LOG2N = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 adv,
    output logic [LOG2N-3:0]     addr,
    output logic                 primed,
    output logic                 frame_head
);
    localparam int K = LOG2N - 2;

    logic [K-1:0] pos;
    logic [K-1:0] pos_rev;
    logic [1:0]   quarter;
    addr_mode_e   mode;

    generate
        for (genvar i = 0; i < K; i++) begin : g_rev
            assign pos_rev[i] = pos[K-1-i];
        end
    endgenerate

    assign mode       = mode_of_quarter(quarter);
    assign addr       = (mode == ADDR_REVERSED) ? pos_rev : pos;
    assign frame_head = (quarter == SOF_QUARTER) && (pos == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos     <= '0;
            quarter <= 2'd0;
            primed  <= 1'b0;
        end else if (adv) begin
            pos <= pos + 1'b1;
            if (&pos) begin
                quarter <= quarter + 2'd1;
                primed  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/unscr_buffer.sv
`timescale 1ns/1ps
module unscr_buffer #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          wen,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Read of the old word and write of the new one share one address.
    assign rdata = mem[addr];

    always_ff @(posedge clk) begin
        if (wen) begin
            mem[addr] <= wdata;
        end
    end
endmodule

// File: rtl/fft_unscrambler.sv
`timescale 1ns/1ps
module fft_unscrambler
    import unscr_pkg::*;
#(
    parameter int LOG2N = 6,
    parameter int W     = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_re,
    input  logic signed [W-1:0] in_im,
    output logic                out_valid,
    output logic                out_sof,
    output logic signed [W-1:0] out_re,
    output logic signed [W-1:0] out_im
);
    localparam int K  = LOG2N - 2;
    localparam int M  = 1 << K;
    localparam int DW = 2 * W;

    typedef struct packed {
        logic signed [W-1:0] re;
        logic signed [W-1:0] im;
    } sample_t;

    logic [K-1:0]  slot;
    logic          primed;
    logic          frame_head;
    sample_t       wr_s;
    sample_t       rd_s;
    logic [DW-1:0] rd_bits;

    assign wr_s = '{re: in_re, im: in_im};
    assign rd_s = sample_t'(rd_bits);

    unscr_addr_gen #(.LOG2N(LOG2N)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .adv        (in_valid),
        .addr       (slot),
        .primed     (primed),
        .frame_head (frame_head)
    );

    unscr_buffer #(.DEPTH(M), .AW(K), .DW(DW)) u_buf (
        .clk   (clk),
        .wen   (in_valid),
        .addr  (slot),
        .wdata (wr_s),
        .rdata (rd_bits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= in_valid && primed;
            out_sof   <= in_valid && primed && frame_head;
            if (in_valid && primed) begin
                out_re <= rd_s.re;
                out_im <= rd_s.im;
            end
        end
    end
endmodule

// File: rtl/unscr_checker.sv
`timescale 1ns/1ps
module unscr_checker #(
    parameter int LOG2N = 6,
    parameter int W     = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                out_valid,
    input logic                out_sof,
    input logic signed [W-1:0] out_re,
    input logic signed [W-1:0] out_im
);
    localparam int N = 1 << LOG2N;
    localparam int M = N / 4;

    int  acc;
    int  vcount;
    bit  seen_sof;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= 0;
            vcount   <= 0;
            seen_sof <= 1'b0;
        end else begin
            if (in_valid && acc < M + 1) acc <= acc + 1;
            if (out_valid) begin
                if (out_sof) begin
                    vcount   <= 1;
                    seen_sof <= 1'b1;
                end else begin
                    vcount <= vcount + 1;
                end
            end
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_sof));

    p_valid_follows_input_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    p_primed_before_output_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (acc == M + 1));

    p_sof_with_valid_r5: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> out_valid);

    p_sof_spacing_r5: assert property (@(posedge clk) disable iff (rst)
        (out_sof && seen_sof) |-> (vcount == N));

    p_hold_on_gap_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) |-> (!out_valid && $stable(out_re) && $stable(out_im)));
endmodule

bind fft_unscrambler unscr_checker #(.LOG2N(LOG2N), .W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_re    (out_re),
    .out_im    (out_im)
);

// File: tb/fft_unscrambler_test.sv
`timescale 1ns/1ps
module fft_unscrambler_test;
    localparam int LOG2N = 6;
    localparam int W     = 16;
    localparam int N     = 1 << LOG2N;
    localparam int K     = LOG2N - 2;
    localparam int M     = N / 4;
    localparam int DEPTH = 4096;

    logic                clk = 1'b0;
    logic                rst;
    logic                in_valid;
    logic signed [W-1:0] in_re, in_im;
    logic                out_valid, out_sof;
    logic signed [W-1:0] out_re, out_im;

    always #2 clk = ~clk;

    fft_unscrambler #(.LOG2N(LOG2N), .W(W)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_sof(out_sof), .out_re(out_re), .out_im(out_im)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [W-1:0] exp_re [DEPTH];
    logic [W-1:0] exp_im [DEPTH];
    int in_cnt, out_cnt, prev_cnt;
    bit prev_v, cont;
    logic [W-1:0] last_re, last_im;
    int unsigned seed_dummy;

    function automatic int rev_k(input int c);
        int r = 0;
        for (int i = 0; i < K; i++) if (c & (1 << i)) r |= 1 << (K - 1 - i);
        return r;
    endfunction

    // natural position of the p-th accepted input
    function automatic int nat_of(input int p);
        int f = p / N;
        int b = (p % N) / M;
        int c = p % M;
        return f * N + b * M + rev_k(c);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic step(input bit v, input bit use_tag,
                        input logic [W-1:0] re_val, input logic [W-1:0] im_val);
        bit ev = prev_v && (prev_cnt >= M);
        int idx;
        chk(out_valid == ev, "R2", "out_valid", out_valid, ev);
        if (cont && prev_v && prev_cnt >= M)
            chk(out_valid == 1'b1, "R4", "continuous out_valid", out_valid, 1);
        if (ev) begin
            chk(out_re == exp_re[out_cnt % DEPTH], "R3", "order tag out_re",
                out_re, exp_re[out_cnt % DEPTH]);
            chk(out_im == exp_im[out_cnt % DEPTH], "R7", "out_im",
                out_im, exp_im[out_cnt % DEPTH]);
            chk(out_sof == (out_cnt % N == 0), "R5", "out_sof",
                out_sof, (out_cnt % N == 0));
            out_cnt++;
        end else begin
            chk(out_sof == 1'b0, "R5", "out_sof without output", out_sof, 0);
            chk(out_re == last_re && out_im == last_im, "R6", "hold out_re",
                out_re, last_re);
        end
        last_re  = out_re;
        last_im  = out_im;
        prev_v   = v;
        prev_cnt = in_cnt;
        if (v) begin
            idx = nat_of(in_cnt);
            in_re = use_tag ? W'(idx) : re_val;
            in_im = im_val;
            exp_re[idx % DEPTH] = in_re;
            exp_im[idx % DEPTH] = in_im;
            in_cnt++;
        end
        in_valid = v;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && out_sof == 1'b0, "R1", "flags in reset", out_valid, 0);
        chk(out_re == 0 && out_im == 0, "R1", "data in reset", out_re, 0);
        rst = 1'b0;
        in_cnt = 0; out_cnt = 0; prev_cnt = 0; prev_v = 0;
        last_re = '0; last_im = '0;
    endtask

    initial begin
        seed_dummy = $urandom(32'd20240611);
        rst = 1'b1; in_valid = 1'b0; in_re = '0; in_im = '0; cont = 0;
        @(negedge clk);
        do_reset();

        // unbroken stream of three frames
        cont = 1;
        for (int i = 0; i < 3 * N; i++) step(1'b1, 1'b1, '0, W'($urandom));

        // random idle cycles
        cont = 0;
        while (in_cnt < 7 * N) step(($urandom % 4) != 0, 1'b1, '0, W'($urandom));

        // directed extremes on both parts, unbroken
        cont = 0;
        step(1'b1, 1'b1, '0, W'($urandom));
        cont = 1;
        for (int i = 0; i < 2 * N; i++) begin
            if (i % 3 == 0)      step(1'b1, 1'b0, 16'h8000, 16'h7fff);
            else if (i % 3 == 1) step(1'b1, 1'b0, 16'h7fff, 16'h8000);
            else                 step(1'b1, 1'b0, W'($urandom), 16'h0000);
        end

        // reset in mid-frame, then restart
        cont = 0;
        for (int i = 0; i < N / 2 + 3; i++) step(1'b1, 1'b1, '0, W'($urandom));
        do_reset();
        chk(out_valid == 1'b0, "R1", "after mid-frame reset", out_valid, 0);
        cont = 1;
        for (int i = 0; i < N + M + 4; i++) step(1'b1, 1'b1, '0, W'($urandom));
        cont = 0;
        step(1'b0, 1'b1, '0, '0);
        step(1'b0, 1'b1, '0, '0);

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 150000, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule